// File: doc/BRIEF.md
# FIFO Level-Crossing Interrupt Generator

This block sits beside the receive and transmit FIFOs of a serial port and raises a raw interrupt flag for each direction when that FIFO's fill level passes through a programmable trigger point. It keeps its own shadow fill count for each FIFO from the push and pop strobes the FIFOs already produce. It compares the pre-update count with the threshold picked by a 3-bit select field.

The receive side fires while it is filling: a push carries the count from the threshold to one above it. The transmit side fires while it is draining: a pop carries the count from one above the threshold down to it. A FIFO that stays at or beyond its threshold does not fire again until it has moved back and crossed once more. Each flag stays set until software pulses the clear strobe for that direction. Masking and interrupt routing are left to the logic downstream.

The two select fields share one register. The transmit select is in bits 2:0, the receive select is in bits 5:3, and all other bits read as zero.

Top module: `fifo_lvl_irq`

## Requirements
- R1: After reset the register reads 0x00000012, both select fields hold 3'b010, both shadow counts are 0 and both raw flags are 0.
- R2: A write stores write-data bits 5:0 (bits 5:3 = receive select, bits 2:0 = transmit select). Bits 31:6 of the register always read 0, whatever was written to them.
- R3: For select codes 0,1,2,3,4 the threshold is 2,4,8,12,14 entries of the 16-entry FIFO. A receive push without a pop, taking the count from the threshold to threshold+1, sets the receive flag on that clock edge.
- R4: The receive flag fires on the crossing only. Once it is cleared, further pushes at or above threshold+1 do not set it again. After the count falls back to the threshold, a new crossing sets it again.
- R5: A transmit pop without a push, taking the count from threshold+1 to the threshold, sets the transmit flag on that clock edge.
- R6: Select codes 5, 6 and 7 never set the flag of the direction they select.
- R7: A raw flag stays set until a one-cycle clear strobe for its direction, which drops it on the next edge.
- R8: A crossing in the same cycle as a clear strobe for that direction leaves the flag set.
- R9: A push and a pop in the same cycle leave the count unchanged and never set a flag.
- R10: Movement the wrong way through the threshold does not fire. A receive pop from threshold+1 to the threshold leaves the receive flag clear, and a transmit push from the threshold to threshold+1 leaves the transmit flag clear.
- R11: A push at a count of 16 and a pop at a count of 0 leave the shadow count unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| rx_push | input | 1 | Receive FIFO write strobe |
| rx_pop | input | 1 | Receive FIFO read strobe |
| tx_push | input | 1 | Transmit FIFO write strobe |
| tx_pop | input | 1 | Transmit FIFO read strobe |
| cfg_wr_en | input | 1 | Level-select register write enable |
| cfg_wdata | input | 32 | Level-select register write data |
| cfg_rdata | output | 32 | Level-select register read-back |
| rx_irq_clr | input | 1 | One-cycle clear for the receive flag |
| tx_irq_clr | input | 1 | One-cycle clear for the transmit flag |
| rx_irq_raw | output | 1 | Receive raw interrupt flag |
| tx_irq_raw | output | 1 | Transmit raw interrupt flag |

## Verification
The bench sweeps all eight select codes in each direction. It steps the count through every value from empty to full and back, and predicts every flag after every step. A level-triggered design would show up as a flag reappearing after a clear while the FIFO stays above its threshold. A design that does not compare in the direction of movement would fire on a receive drain or a transmit fill. The bench also targets a push and pop in the same cycle exactly at the threshold, a clear that lands on a crossing, pushes at full that a wrapping counter would turn into a phantom crossing, and reserved codes that an unguarded decoder would map to some threshold.

// File: rtl/lvlint_pkg.sv
// Package: shared types and threshold decoding for the FIFO level-crossing
// interrupt generator. Assumes a 3-bit select code per direction.
package lvlint_pkg;

    localparam int SEL_W = 3;

    typedef logic [SEL_W-1:0] lvl_sel_t;

    // Sense in which a FIFO must move to count as a crossing.
    typedef enum logic {
        DIR_FILL  = 1'b0,
        DIR_DRAIN = 1'b1
    } cross_dir_e;

    // Select code to threshold in eighths of the FIFO depth; 0 for reserved codes.
    function automatic int unsigned sel_to_eighths(lvl_sel_t s);
        case (s)
            3'd0:    return 1;
            3'd1:    return 2;
            3'd2:    return 4;
            3'd3:    return 6;
            3'd4:    return 7;
            default: return 0;
        endcase
    endfunction

    // True for the five defined select codes.
    function automatic logic sel_is_valid(lvl_sel_t s);
        return (s <= 3'd4);
    endfunction

endpackage

// File: rtl/lvl_fill_tracker.sv
// Shadow fill counter for one FIFO plus crossing detector.
// Counts push-only and pop-only cycles and ignores push at full, pop at empty
// and push with pop. Compares the count before the update with the decoded
// threshold; the crossing output is combinational and valid in the cycle of
// the strobe. Assumes DEPTH is a multiple of 8.
module lvl_fill_tracker
    import lvlint_pkg::*;
#(
    parameter int         DEPTH = 16,
    parameter cross_dir_e DIR   = DIR_FILL,
    localparam int        CNT_W = $clog2(DEPTH + 1)
) (
    input  logic     clk,
    input  logic     rst_n,
    input  logic     push,
    input  logic     pop,
    input  lvl_sel_t sel,
    output logic     crossing
);

    localparam logic [CNT_W-1:0] FULL = CNT_W'(DEPTH);

    logic [CNT_W-1:0] count;
    logic [CNT_W-1:0] thr;
    logic [CNT_W-1:0] thr_up;
    logic             inc;
    logic             dec;

    // Threshold decode from the select code.
    always_comb begin
        thr    = CNT_W'((DEPTH * sel_to_eighths(sel)) / 8);
        thr_up = thr + 1'b1;
    end

    // Net movement of the FIFO this cycle, with bounds guarded.
    always_comb begin
        inc = push && !pop && (count != FULL);
        dec = pop && !push && (count != '0);
    end

    // Shadow fill count.
    always_ff @(posedge clk) begin
        if (!rst_n)
            count <= '0;
        else if (inc)
            count <= count + 1'b1;
        else if (dec)
            count <= count - 1'b1;
    end

    // Crossing detection, sense picked by the direction parameter.
    generate
        if (DIR == DIR_FILL) begin : g_fill
            always_comb crossing = sel_is_valid(sel) && inc && (count == thr);
        end else begin : g_drain
            always_comb crossing = sel_is_valid(sel) && dec && (count == thr_up);
        end
    endgenerate

endmodule

// File: rtl/lvl_sel_reg.sv
// Level-select register: two select fields with a half-full reset code.
// Keeps only the field bits; all other bits read back as zero.
module lvl_sel_reg
    import lvlint_pkg::*;
#(
    parameter int       REG_W     = 32,
    parameter int       TX_LSB    = 0,
    parameter int       RX_LSB    = 3,
    parameter lvl_sel_t RESET_SEL = 3'd2,
    localparam int      USED_W    = RX_LSB + SEL_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [REG_W-1:0] wdata,
    output lvl_sel_t         rx_sel,
    output lvl_sel_t         tx_sel,
    output logic [REG_W-1:0] rdata
);

    logic unused_wbits;

    // Upper write bits have no storage.
    assign unused_wbits = ^wdata[REG_W-1:USED_W];

    // Field storage with reset code.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rx_sel <= RESET_SEL;
            tx_sel <= RESET_SEL;
        end else if (wr_en) begin
            rx_sel <= wdata[RX_LSB +: SEL_W];
            tx_sel <= wdata[TX_LSB +: SEL_W];
        end
    end

    // Read-back assembly.
    always_comb begin
        rdata                   = '0;
        rdata[RX_LSB +: SEL_W]  = rx_sel;
        rdata[TX_LSB +: SEL_W]  = tx_sel;
    end

endmodule

// File: rtl/lvl_raw_flag.sv
// Sticky raw interrupt flag: set wins over clear in the same cycle.
module lvl_raw_flag (
    input  logic clk,
    input  logic rst_n,
    input  logic set,
    input  logic clr,
    output logic flag
);

    // Flag state update.
    always_ff @(posedge clk) begin
        if (!rst_n)
            flag <= 1'b0;
        else if (set)
            flag <= 1'b1;
        else if (clr)
            flag <= 1'b0;
    end

endmodule

// File: rtl/fifo_lvl_irq.sv
// Top: FIFO level-crossing interrupt generator for a receive and a transmit
// FIFO. Index 0 of the internal arrays is receive (fill sense), index 1 is
// transmit (drain sense). Assumes the strobes are one per FIFO access.
module fifo_lvl_irq
    import lvlint_pkg::*;
#(
    parameter int FIFO_DEPTH = 16,
    parameter int REG_W      = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             rx_push,
    input  logic             rx_pop,
    input  logic             tx_push,
    input  logic             tx_pop,
    input  logic             cfg_wr_en,
    input  logic [REG_W-1:0] cfg_wdata,
    output logic [REG_W-1:0] cfg_rdata,
    input  logic             rx_irq_clr,
    input  logic             tx_irq_clr,
    output logic             rx_irq_raw,
    output logic             tx_irq_raw
);

    localparam int N_DIR = 2;

    logic [N_DIR-1:0] push_v;
    logic [N_DIR-1:0] pop_v;
    logic [N_DIR-1:0] clr_v;
    logic [N_DIR-1:0] set_v;
    logic [N_DIR-1:0] raw_v;
    lvl_sel_t         sel_v [N_DIR];

    // Gather per-direction strobes.
    always_comb begin
        push_v = {tx_push, rx_push};
        pop_v  = {tx_pop, rx_pop};
        clr_v  = {tx_irq_clr, rx_irq_clr};
    end

    lvl_sel_reg #(
        .REG_W (REG_W)
    ) u_sel (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_en  (cfg_wr_en),
        .wdata  (cfg_wdata),
        .rx_sel (sel_v[0]),
        .tx_sel (sel_v[1]),
        .rdata  (cfg_rdata)
    );

    generate
        for (genvar d = 0; d < N_DIR; d++) begin : g_dir
            lvl_fill_tracker #(
                .DEPTH (FIFO_DEPTH),
                .DIR   ((d == 0) ? DIR_FILL : DIR_DRAIN)
            ) u_trk (
                .clk      (clk),
                .rst_n    (rst_n),
                .push     (push_v[d]),
                .pop      (pop_v[d]),
                .sel      (sel_v[d]),
                .crossing (set_v[d])
            );

            lvl_raw_flag u_flag (
                .clk   (clk),
                .rst_n (rst_n),
                .set   (set_v[d]),
                .clr   (clr_v[d]),
                .flag  (raw_v[d])
            );
        end
    endgenerate

    // Drive output flags.
    always_comb begin
        rx_irq_raw = raw_v[0];
        tx_irq_raw = raw_v[1];
    end

endmodule

// File: rtl/fifo_lvl_irq_chk.sv
// Checker for fifo_lvl_irq, attached with bind. Sees the ports plus the
// per-direction crossing strobes.
module fifo_lvl_irq_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        rx_push,
    input logic        rx_pop,
    input logic        tx_push,
    input logic        tx_pop,
    input logic        rx_clr,
    input logic        tx_clr,
    input logic [31:0] rdata,
    input logic        rx_raw,
    input logic        tx_raw,
    input logic        rx_set,
    input logic        tx_set
);

    a_r1_reset_state: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (rdata == 32'h12) && !rx_raw && !tx_raw);

    a_r2_upper_zero: assert property (@(posedge clk) disable iff (!rst_n)
        rdata[31:6] == 26'd0);

    a_r6_rx_reserved: assert property (@(posedge clk) disable iff (!rst_n)
        (rdata[5:3] > 3'd4) && !rx_raw |=> !rx_raw);

    a_r6_tx_reserved: assert property (@(posedge clk) disable iff (!rst_n)
        (rdata[2:0] > 3'd4) && !tx_raw |=> !tx_raw);

    a_r7_rx_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        rx_raw && !rx_clr |=> rx_raw);

    a_r7_tx_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        tx_raw && !tx_clr |=> tx_raw);

    a_r7_rx_clear: assert property (@(posedge clk) disable iff (!rst_n)
        rx_clr && !rx_set |=> !rx_raw);

    a_r7_tx_clear: assert property (@(posedge clk) disable iff (!rst_n)
        tx_clr && !tx_set |=> !tx_raw);

    a_r8_rx_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
        rx_set |=> rx_raw);

    a_r8_tx_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
        tx_set |=> tx_raw);

    a_r9_rx_both: assert property (@(posedge clk) disable iff (!rst_n)
        rx_push && rx_pop && !rx_raw |=> !rx_raw);

    a_r9_tx_both: assert property (@(posedge clk) disable iff (!rst_n)
        tx_push && tx_pop && !tx_raw |=> !tx_raw);

    a_r10_rx_drain: assert property (@(posedge clk) disable iff (!rst_n)
        rx_pop && !rx_push && !rx_raw |=> !rx_raw);

    a_r10_tx_fill: assert property (@(posedge clk) disable iff (!rst_n)
        tx_push && !tx_pop && !tx_raw |=> !tx_raw);

endmodule

bind fifo_lvl_irq fifo_lvl_irq_chk u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .rx_push (rx_push),
    .rx_pop  (rx_pop),
    .tx_push (tx_push),
    .tx_pop  (tx_pop),
    .rx_clr  (rx_irq_clr),
    .tx_clr  (tx_irq_clr),
    .rdata   (cfg_rdata),
    .rx_raw  (rx_irq_raw),
    .tx_raw  (tx_irq_raw),
    .rx_set  (set_v[0]),
    .tx_set  (set_v[1])
);

// File: tb/sim_fifo_lvl_irq.sv
`timescale 1ns/1ps
module sim_fifo_lvl_irq;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        rx_push = 0, rx_pop = 0, tx_push = 0, tx_pop = 0;
    logic        cfg_wr_en = 0;
    logic [31:0] cfg_wdata = '0;
    logic [31:0] cfg_rdata;
    logic        rx_irq_clr = 0, tx_irq_clr = 0;
    logic        rx_irq_raw, tx_irq_raw;

    int checks = 0;
    int errors = 0;

    // Bench model state
    int   m_rxcnt, m_txcnt;
    int   m_rsel, m_tsel;
    logic m_rx, m_tx;

    always #5 clk = ~clk;

    fifo_lvl_irq u0 (
        .clk        (clk),
        .rst_n      (rst_n),
        .rx_push    (rx_push),
        .rx_pop     (rx_pop),
        .tx_push    (tx_push),
        .tx_pop     (tx_pop),
        .cfg_wr_en  (cfg_wr_en),
        .cfg_wdata  (cfg_wdata),
        .cfg_rdata  (cfg_rdata),
        .rx_irq_clr (rx_irq_clr),
        .tx_irq_clr (tx_irq_clr),
        .rx_irq_raw (rx_irq_raw),
        .tx_irq_raw (tx_irq_raw)
    );

    function automatic bit valid_sel(int s);
        return s >= 0 && s <= 4;
    endfunction

    // Threshold in entries of 16 (R3); reserved codes get a nominal 8 for walking.
    function automatic int thr_of(int s);
        case (s)
            0: return 2;
            1: return 4;
            2: return 8;
            3: return 12;
            4: return 14;
            default: return 8;
        endcase
    endfunction

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    // One clock of stimulus; model updated from the requirements.
    task automatic step(logic rpu, logic rpo, logic tpu, logic tpo, logic rc, logic tc);
        bit rx_hit, tx_hit;
        rx_push = rpu; rx_pop = rpo; tx_push = tpu; tx_pop = tpo;
        rx_irq_clr = rc; tx_irq_clr = tc;
        rx_hit = valid_sel(m_rsel) && rpu && !rpo && m_rxcnt < 16 && m_rxcnt == thr_of(m_rsel);
        tx_hit = valid_sel(m_tsel) && tpo && !tpu && m_txcnt > 0 && m_txcnt == thr_of(m_tsel) + 1;
        m_rx = rx_hit | (m_rx & !rc);
        m_tx = tx_hit | (m_tx & !tc);
        if (rpu && !rpo && m_rxcnt < 16) m_rxcnt++;
        if (rpo && !rpu && m_rxcnt > 0)  m_rxcnt--;
        if (tpu && !tpo && m_txcnt < 16) m_txcnt++;
        if (tpo && !tpu && m_txcnt > 0)  m_txcnt--;
        @(posedge clk);
        #2;
        rx_push = 0; rx_pop = 0; tx_push = 0; tx_pop = 0;
        rx_irq_clr = 0; tx_irq_clr = 0;
    endtask

    task automatic wr(logic [31:0] d);
        cfg_wr_en = 1; cfg_wdata = d;
        @(posedge clk);
        #2;
        cfg_wr_en = 0; cfg_wdata = '0;
        m_rsel = int'(d[5:3]);
        m_tsel = int'(d[2:0]);
    endtask

    task automatic do_reset();
        rst_n = 0;
        repeat (2) @(posedge clk);
        #2;
        rst_n = 1;
        m_rxcnt = 0; m_txcnt = 0; m_rsel = 2; m_tsel = 2; m_rx = 0; m_tx = 0;
        chk("R1 reset readback", cfg_rdata, 32'h12);
        chk("R1 reset rx flag", {31'd0, rx_irq_raw}, 32'd0);
        chk("R1 reset tx flag", {31'd0, tx_irq_raw}, 32'd0);
    endtask

    task automatic sweep_rx(int s);
        int t;
        t = thr_of(s);
        do_reset();
        wr({26'd0, 3'(s), 3'd2});
        // R3/R6 fill walk, R11 push at full
        for (int k = 0; k < 17; k++) begin
            step(1, 0, 0, 0, 0, 0);
            chk(k == 16 ? "R11 rx push at full" : (valid_sel(s) ? "R3 rx fill" : "R6 rx reserved"),
                {31'd0, rx_irq_raw}, {31'd0, m_rx});
        end
        step(0, 0, 0, 0, 1, 0);
        chk("R7 rx clear", {31'd0, rx_irq_raw}, 32'd0);
        step(1, 0, 0, 0, 0, 0);
        chk("R4 rx no retrigger at full", {31'd0, rx_irq_raw}, 32'd0);
        // R10 drain through threshold does not fire
        while (m_rxcnt > t) begin
            step(0, 1, 0, 0, 0, 0);
            chk("R10 rx drain", {31'd0, rx_irq_raw}, 32'd0);
        end
        step(1, 1, 0, 0, 0, 0);
        chk("R9 rx push+pop at threshold", {31'd0, rx_irq_raw}, 32'd0);
        step(1, 0, 0, 0, 1, 0);
        chk("R8 rx crossing with clear", {31'd0, rx_irq_raw}, {31'd0, m_rx});
        step(1, 0, 0, 0, 1, 0);
        chk("R4 rx above threshold stays clear", {31'd0, rx_irq_raw}, 32'd0);
        // drain to empty, pop at empty (R11), refill to show re-trigger (R4)
        while (m_rxcnt > 0) step(0, 1, 0, 0, 0, 0);
        step(0, 1, 0, 0, 0, 0);
        for (int k = 0; k < 16; k++) begin
            step(1, 0, 0, 0, 0, 0);
            chk("R4 rx retrigger after refill", {31'd0, rx_irq_raw}, {31'd0, m_rx});
        end
    endtask

    task automatic sweep_tx(int s);
        int t;
        t = thr_of(s);
        do_reset();
        wr({26'd0, 3'd2, 3'(s)});
        // R10 fill through threshold does not fire
        for (int k = 0; k < 16; k++) begin
            step(0, 0, 1, 0, 0, 0);
            chk("R10 tx fill", {31'd0, tx_irq_raw}, 32'd0);
        end
        // R5/R6 drain walk, R11 pop at empty
        for (int k = 0; k < 17; k++) begin
            step(0, 0, 0, 1, 0, 0);
            chk(k == 16 ? "R11 tx pop at empty" : (valid_sel(s) ? "R5 tx drain" : "R6 tx reserved"),
                {31'd0, tx_irq_raw}, {31'd0, m_tx});
        end
        step(0, 0, 0, 0, 0, 1);
        chk("R7 tx clear", {31'd0, tx_irq_raw}, 32'd0);
        while (m_txcnt < t + 1) step(0, 0, 1, 0, 0, 0);
        step(0, 0, 1, 1, 0, 0);
        chk("R9 tx push+pop above threshold", {31'd0, tx_irq_raw}, 32'd0);
        step(0, 0, 0, 1, 0, 1);
        chk("R8 tx crossing with clear", {31'd0, tx_irq_raw}, {31'd0, m_tx});
        step(0, 0, 0, 1, 0, 1);
        chk("R7 tx below threshold cleared", {31'd0, tx_irq_raw}, 32'd0);
    endtask

    initial begin
        #1_000_000;
        errors++;
        $display("FAIL watchdog: actual hung expected done");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #2;
        do_reset();
        wr(32'hFFFF_FFFF);
        chk("R2 upper bits read zero", cfg_rdata, 32'h3F);
        wr(32'hDEAD_BEEF);
        chk("R2 fields stored", cfg_rdata, 32'h2F);
        wr(32'hFFFF_FFC0);
        chk("R2 only upper bits written", cfg_rdata, 32'h0);
        for (int s = 0; s < 8; s++) sweep_rx(s);
        for (int s = 0; s < 8; s++) sweep_tx(s);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule